// File: doc/BRIEF.md
# Readback CRC Word Checker

This block sits beside a serial configuration-readback port and checks, on every pass, the checksum word that the port emits once it has shifted out the whole configuration image. A pass opens with a one-cycle start pulse. After that the block counts bit positions, one per clock of the free-running readback oscillator. It collects the last `CRC_W` bits of each `FRAME_LEN`-bit pass into a capture register and compares the result with an expected word that arrives on a port. That word is held outside the logic under check, so the checksum does not have to describe a value stored inside the checked image.

Readback runs in a continuous loop, so the block judges each pass on its own. At the end of every pass it gives a one-cycle completion strobe and a per-pass match flag. A sticky fault flag records any mismatch until reset. The block does not compute the checksum; it only finds the word and compares it. A new start pulse that arrives before a pass is complete drops that pass without judging it.

Top module: `rb_crc_check`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, done_o, pass_o and err_o are all 0.
- R2: A cycle with start_i high carries bit position 0 of a pass on data_i. Positions 1 to FRAME_LEN-1 follow on the next consecutive clock cycles, one per cycle.
- R3: The check word is taken from positions FRAME_LEN-CRC_W to FRAME_LEN-1. The first of these is the word's most significant bit and the last is its bit 0.
- R4: done_o is high for exactly one cycle: the cycle after the one that carries position FRAME_LEN-1. It is low in every other cycle.
- R5: When done_o rises, pass_o becomes 1 if the captured word equals the ref_crc_i value present in the cycle of the last bit, and 0 otherwise. pass_o holds its value between completions.
- R6: err_o becomes 1 together with any completion whose pass_o is 0. It then stays 1 until reset, and it never rises at any other time.
- R7: A start_i pulse at any position after 0 of a pass in progress drops that pass with no done_o and no change to err_o, and opens a new pass at position 0.
- R8: data_i at positions 0 to FRAME_LEN-CRC_W-1 has no effect on pass_o or err_o.
- R9: Once a pass is complete, data_i is ignored and no further done_o occurs until the next start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running readback clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks bit position 0 of a readback pass |
| data_i | input | 1 | Serial readback bit |
| ref_crc_i | input | CRC_W | Expected check word, held outside the checked logic |
| done_o | output | 1 | One-cycle strobe after the last bit of a pass |
| pass_o | output | 1 | Result of the most recent completed pass |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
The bench uses a small configuration of 12 bits with a 4-bit word. It runs every pairing of captured word and reference, which shows that a match sets pass_o and leaves err_o clear while every single-bit or multi-bit difference is caught. This sweep would also expose a bit-order reversal, because reversed words differ for most values. The payload bits ahead of the word come from a pseudo-random sequence, so an off-by-one window that took a payload bit into the word would show up as false mismatches. The bench also restarts a pass at mid-frame with a bad word and feeds long idle stretches with no start pulse. These separate the abort and idle behaviour from normal completion.

// File: rtl/rb_crc_pkg.sv
package rb_crc_pkg;
  // first bit position of the check word inside a pass
  function automatic int unsigned word_first_pos(int unsigned frame_len, int unsigned word_w);
    return frame_len - word_w;
  endfunction

  typedef struct packed {
    logic in_word;
    logic last;
  } pos_flags_t;
endpackage

// File: rtl/rb_pos_counter.sv
module rb_pos_counter
  import rb_crc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned CRC_W     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output pos_flags_t flags_o
);
  localparam int unsigned PW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] WORD_POS = PW'(word_first_pos(FRAME_LEN, CRC_W));

  logic          active_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur_pos;
  logic          cur_valid;

  assign cur_pos   = start_i ? '0 : pos_q;
  assign cur_valid = start_i | active_q;

  always_comb begin
    flags_o.in_word = cur_valid && (cur_pos >= WORD_POS);
    flags_o.last    = cur_valid && (cur_pos == LAST_POS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pos_q    <= PW'(1);
    end else if (active_q) begin
      if (flags_o.last) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/rb_word_capture.sv
module rb_word_capture #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             data_i,
  output logic [CRC_W-1:0] word_o
);
  // word_o includes the bit presented this cycle, so it is whole on the last bit
  generate
    if (CRC_W == 1) begin : g_single
      assign word_o = data_i;
    end else begin : g_shift
      logic [CRC_W-2:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[CRC_W-3 >= 0 ? CRC_W-3 : 0:0], data_i} ;
      end
      assign word_o = {sr_q, data_i};
    end
  endgenerate
endmodule

// File: rtl/rb_word_compare.sv
module rb_word_compare #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_i,
  input  logic [CRC_W-1:0] word_i,
  input  logic [CRC_W-1:0] ref_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             err_o
);
  logic match;
  assign match = (word_i == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) begin
        pass_o <= match;
        if (!match) err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rb_crc_check.sv
module rb_crc_check
  import rb_crc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned CRC_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_i,
  input  logic [CRC_W-1:0] ref_crc_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             err_o
);
  pos_flags_t       flags;
  logic [CRC_W-1:0] word;

  initial begin
    if (FRAME_LEN <= CRC_W) $error("FRAME_LEN must exceed CRC_W");
  end

  rb_pos_counter #(.FRAME_LEN(FRAME_LEN), .CRC_W(CRC_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .flags_o (flags)
  );

  rb_word_capture #(.CRC_W(CRC_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (flags.in_word),
    .data_i  (data_i),
    .word_o  (word)
  );

  rb_word_compare #(.CRC_W(CRC_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (flags.last),
    .word_i (word),
    .ref_i  (ref_crc_i),
    .done_o (done_o),
    .pass_o (pass_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/rb_crc_check_chk.sv
module rb_crc_check_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic done_o,
  input logic pass_o,
  input logic err_o
);
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R6
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (done_o && !pass_o));

  // R6
  fail_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> err_o);

  // R5
  pass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pass_o));

  // R7
  start_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

bind rb_crc_check rb_crc_check_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .pass_o  (pass_o),
  .err_o   (err_o)
);

// File: tb/rb_crc_check_tb.sv
module rb_crc_check_tb;
  localparam int unsigned FL = 12;
  localparam int unsigned CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          data_i = 1'b0;
  logic [CW-1:0] ref_crc_i = '0;
  logic          done_o, pass_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_err = 1'b0;
  logic exp_pass = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  rb_crc_check #(.FRAME_LEN(FL), .CRC_W(CW)) u_dut (
    .clk_i, .rst_ni, .start_i, .data_i, .ref_crc_i, .done_o, .pass_o, .err_o
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // drive n bits of a pass (R2, R3); check done stays low inside it (R4, R7)
  task automatic drive_bits(input logic [CW-1:0] word, input logic [CW-1:0] refv, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (i > 0) chk(done_o == 1'b0, "R4 done inside pass", int'(done_o), 0);
      start_i   = (i == 0);
      data_i    = (i >= int'(FL - CW)) ? word[FL-1-i] : next_bit();
      ref_crc_i = refv;
    end
  endtask

  task automatic full_pass(input logic [CW-1:0] word, input logic [CW-1:0] refv);
    drive_bits(word, refv, FL);
    @(negedge clk_i);
    exp_pass = (word == refv);
    if (!exp_pass) exp_err = 1'b1;
    chk(done_o == 1'b1, "R4 done after last bit", int'(done_o), 1);
    chk(pass_o == exp_pass, "R5 pass result", int'(pass_o), int'(exp_pass));
    chk(err_o == exp_err, "R6 err flag", int'(err_o), int'(exp_err));
    start_i   = 1'b0;
    data_i    = next_bit();
    ref_crc_i = ~refv;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
    chk(pass_o == exp_pass, "R5 pass held", int'(pass_o), int'(exp_pass));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_i = 1'b0;
    @(negedge clk_i);
    chk({done_o, pass_o, err_o} == 3'b000, "R1 in reset", int'({done_o, pass_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({done_o, pass_o, err_o} == 3'b000, "R1 after reset", int'({done_o, pass_o, err_o}), 0);
    exp_err = 1'b0;
    exp_pass = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R3 R8: every word matching, random payload
    for (int w = 0; w < (1 << CW); w++) full_pass(CW'(w), CW'(w));

    // R7: abort a bad pass mid-frame, then a matching pass
    for (int ab = 1; ab < int'(FL); ab++) begin
      drive_bits(4'hA, 4'h5, ab);
      chk(err_o == 1'b0, "R7 no err on abort", int'(err_o), 0);
      full_pass(4'h3, 4'h3);
    end

    // R9: idle bits with no start
    for (int i = 0; i < int'(2 * FL); i++) begin
      @(negedge clk_i);
      chk(done_o == 1'b0, "R9 idle no done", int'(done_o), 0);
      start_i = 1'b0;
      data_i  = next_bit();
    end
    chk(pass_o == exp_pass, "R9 pass untouched", int'(pass_o), int'(exp_pass));

    // R5 R6: exhaustive word x reference
    for (int w = 0; w < (1 << CW); w++) begin
      for (int r = 0; r < (1 << CW); r++) begin
        do_reset();
        full_pass(CW'(w), CW'(r));
        full_pass(CW'(r), CW'(r));
        chk(err_o == (w != r), "R6 sticky after match", int'(err_o), int'(w != r));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule